// File: doc/BRIEF.md
# Weighted Joint Intensity Histogram Accumulator

This block builds the joint intensity histogram that a mutual-information stage needs for image registration. Each accepted voxel brings one reference-image intensity, eight floating-image intensities (one for each of the eight neighbours produced by partial-volume interpolation) and eight fractional weights. Both intensities are reduced to their top `BIN_W` bits. Together they select a bin, and each weight is added to its bin. The storage is split into eight banks. Neighbour k always goes to bank k, and every bank has its own adder, so all eight contributions of a voxel are absorbed in one cycle. Each bank word holds `INT_W + FRAC_W` bits (8 integer, 8 fraction).

A bank pipelines its read-modify-write over two cycles. A hit on the bin written in the previous cycle takes its base value from the pending write and not from the stale memory read. When the last voxel has been accepted, a dump request streams every bin in row-major order, one word per cycle, as the sum of the eight bank words. The last bin carries a last flag. A clear sequence zeroes all banks after reset and whenever it is requested. `busy` is high during clear, drain and dump, and no voxel is taken while it is high. The target configuration is 64x64 bins (`BIN_W = 6`). The default `BIN_W = 4` (16x16) keeps the elaborated memories small.

Top module: `mh_accum`

States of the controller: `ST_CLEAR` (walks every address writing zero, then goes to `ST_IDLE`), `ST_IDLE` (accepts voxels; `clear_req` goes to `ST_CLEAR`, otherwise `done_req` goes to `ST_DRAIN`), `ST_DRAIN` (one cycle for the last write to land, then goes to `ST_DUMP`), `ST_DUMP` (walks every address reading all banks, then goes to `ST_IDLE`). Reset enters `ST_CLEAR`.

## Requirements
- R1: While reset is applied and after it is released, `busy` is high. It stays high for exactly 2^(2*BIN_W) cycles of clearing, and afterwards every bin reads zero.
- R2: Bin index = ref_bin * 2^BIN_W + flt_bin, with ref_bin and flt_bin the top BIN_W bits of the reference intensity and of the floating intensity. Neighbour k uses `flt_pix[k*INT_W +: INT_W]` and `wgt[k*WORD_W +: WORD_W]`. An accepted voxel adds weight k to the bin of (reference, floating k) for every k.
- R3: When all eight neighbours of one voxel select the same bin, that bin grows by the sum of all eight weights.
- R4: Voxels accepted in back-to-back cycles that hit the same bin all count. No update is lost.
- R5: `vox_valid` is ignored while `busy` is high and in any cycle where `clear_req` is high.
- R6: `done_req` in idle raises `busy` on the next cycle. The block then emits exactly 2^(2*BIN_W) words on `out_valid` in consecutive cycles, in ascending bin index (row-major, reference as row). `out_last` is high only with the final word.
- R7: A voxel presented in the same cycle as `done_req` is counted in the dump.
- R8: `clear_req` in idle zeroes every bin. `busy` rises on the next cycle and stays high for 2^(2*BIN_W) cycles.
- R9: A dump does not change the histogram. Dumping twice gives identical words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_req | input | 1 | Start a clear sequence (taken in idle) |
| done_req | input | 1 | Last voxel has been sent; start the dump (taken in idle) |
| vox_valid | input | 1 | Voxel inputs are valid this cycle |
| ref_pix | input | INT_W | Reference-image intensity |
| flt_pix | input | 8*INT_W | Floating-image intensities, neighbour k in slice k |
| wgt | input | 8*(INT_W+FRAC_W) | Interpolation weights, neighbour k in slice k |
| busy | output | 1 | Clearing, draining or dumping; voxels are refused |
| out_valid | output | 1 | A summed bin word is on `out_bin` |
| out_bin | output | INT_W+FRAC_W+3 | Bin value summed over all banks |
| out_last | output | 1 | Marks the final bin of the dump |

## Verification
Directed voxels with eight distinct floating intensities show whether each neighbour reaches its own bank and the right bin. Voxels whose eight neighbours share one bin show that the banks merge correctly at read-out. Runs of identical voxels on consecutive cycles expose a missing or wrong forwarding path, which a spaced-out stream would hide. Random voxels confined to a few bins, with random gaps, mix forwarded and non-forwarded updates. Voxels driven during clear, during dump and together with `clear_req` show whether the refusal rules hold. Two dumps in a row show that read-out does not disturb the histogram.

// File: rtl/mh_pkg.sv
package mh_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DUMP  = 2'd3
    } mh_state_e;

endpackage

// File: rtl/mh_bank.sv
module mh_bank #(
    parameter int AW     = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_vld,
    input  logic [AW-1:0]     upd_addr,
    input  logic [WORD_W-1:0] upd_wgt,
    input  logic              clr_vld,
    input  logic [AW-1:0]     clr_addr,
    input  logic [AW-1:0]     dmp_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_q;
    logic [AW-1:0]     rd_sel;

    logic              s1_vld;
    logic [AW-1:0]     s1_addr;
    logic [WORD_W-1:0] s1_wgt;
    logic              wb_vld;
    logic [AW-1:0]     wb_addr;
    logic [WORD_W-1:0] wb_data;
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] acc_sum;

    assign rd_sel = upd_vld ? upd_addr : dmp_addr;

    // take the base from the write of the previous cycle when it hits the same bin
    always_comb begin
        base    = (wb_vld && (wb_addr == s1_addr)) ? wb_data : rd_q;
        acc_sum = base + s1_wgt;
    end

    always_ff @(posedge clk) begin
        rd_q <= mem[rd_sel];
    end

    always_ff @(posedge clk) begin
        if (s1_vld) begin
            mem[s1_addr] <= acc_sum;
        end else if (clr_vld) begin
            mem[clr_addr] <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_addr <= '0;
            s1_wgt  <= '0;
            wb_vld  <= 1'b0;
            wb_addr <= '0;
            wb_data <= '0;
        end else begin
            s1_vld  <= upd_vld;
            s1_addr <= upd_addr;
            s1_wgt  <= upd_wgt;
            wb_vld  <= s1_vld;
            wb_addr <= s1_addr;
            wb_data <= acc_sum;
        end
    end

    assign rd_word = rd_q;

endmodule

// File: rtl/mh_ctrl.sv
module mh_ctrl
    import mh_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_req,
    input  logic          done_req,
    output logic          busy,
    output logic          acc_en,
    output logic          clr_vld,
    output logic [AW-1:0] clr_addr,
    output logic          dmp_fire,
    output logic [AW-1:0] dmp_addr,
    output logic          dmp_last
);
    mh_state_e     state;
    mh_state_e     nxt;
    logic [AW-1:0] cnt;
    logic          cnt_last;

    assign cnt_last = &cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLEAR;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state != nxt) begin
            cnt <= '0;
        end else if ((state == ST_CLEAR) || (state == ST_DUMP)) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_CLEAR: if (cnt_last) nxt = ST_IDLE;
            ST_IDLE: begin
                if (clear_req) begin
                    nxt = ST_CLEAR;
                end else if (done_req) begin
                    nxt = ST_DRAIN;
                end
            end
            ST_DRAIN: nxt = ST_DUMP;
            ST_DUMP:  if (cnt_last) nxt = ST_IDLE;
            default:  nxt = ST_CLEAR;
        endcase
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        acc_en   = (state == ST_IDLE) && !clear_req;
        clr_vld  = (state == ST_CLEAR);
        clr_addr = cnt;
        dmp_fire = (state == ST_DUMP);
        dmp_addr = cnt;
        dmp_last = (state == ST_DUMP) && cnt_last;
    end

endmodule

// File: rtl/mh_merge.sv
module mh_merge #(
    parameter int N_NB   = 8,
    parameter int WORD_W = 16,
    parameter int SUM_W  = 19
) (
    input  logic [N_NB*WORD_W-1:0] words,
    output logic [SUM_W-1:0]       total
);
    always_comb begin
        total = '0;
        for (int k = 0; k < N_NB; k++) begin
            total = total + SUM_W'(words[k*WORD_W +: WORD_W]);
        end
    end

endmodule

// File: rtl/mh_accum.sv
module mh_accum #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 8,
    parameter int BIN_W  = 4,
    parameter int N_NB   = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clear_req,
    input  logic                              done_req,
    input  logic                              vox_valid,
    input  logic [INT_W-1:0]                  ref_pix,
    input  logic [N_NB*INT_W-1:0]             flt_pix,
    input  logic [N_NB*(INT_W+FRAC_W)-1:0]    wgt,
    output logic                              busy,
    output logic                              out_valid,
    output logic [INT_W+FRAC_W+$clog2(N_NB)-1:0] out_bin,
    output logic                              out_last
);
    localparam int WORD_W = INT_W + FRAC_W;
    localparam int AW     = 2 * BIN_W;
    localparam int SUM_W  = WORD_W + $clog2(N_NB);

    logic              acc_en;
    logic              acc_fire;
    logic              clr_vld;
    logic [AW-1:0]     clr_addr;
    logic              dmp_fire;
    logic [AW-1:0]     dmp_addr;
    logic              dmp_last;
    logic [BIN_W-1:0]  ref_bin;
    logic [N_NB*WORD_W-1:0] bank_rd;
    logic [SUM_W-1:0]  merged;
    logic              dv1;
    logic              dl1;
    logic              unused_low;

    assign unused_low = ^{ref_pix, flt_pix};
    assign acc_fire   = vox_valid & acc_en;
    assign ref_bin    = ref_pix[INT_W-1 -: BIN_W];

    mh_ctrl #(.AW(AW)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_req(clear_req),
        .done_req (done_req),
        .busy     (busy),
        .acc_en   (acc_en),
        .clr_vld  (clr_vld),
        .clr_addr (clr_addr),
        .dmp_fire (dmp_fire),
        .dmp_addr (dmp_addr),
        .dmp_last (dmp_last)
    );

    for (genvar k = 0; k < N_NB; k++) begin : g_bank
        logic [BIN_W-1:0] flt_bin;
        logic [AW-1:0]    addr;
        assign flt_bin = flt_pix[k*INT_W + INT_W-1 -: BIN_W];
        assign addr    = {ref_bin, flt_bin};

        mh_bank #(.AW(AW), .WORD_W(WORD_W)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_vld (acc_fire),
            .upd_addr(addr),
            .upd_wgt (wgt[k*WORD_W +: WORD_W]),
            .clr_vld (clr_vld),
            .clr_addr(clr_addr),
            .dmp_addr(dmp_addr),
            .rd_word (bank_rd[k*WORD_W +: WORD_W])
        );
    end

    mh_merge #(.N_NB(N_NB), .WORD_W(WORD_W), .SUM_W(SUM_W)) merge_i (
        .words(bank_rd),
        .total(merged)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv1       <= 1'b0;
            dl1       <= 1'b0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_bin   <= '0;
        end else begin
            dv1       <= dmp_fire;
            dl1       <= dmp_last;
            out_valid <= dv1;
            out_last  <= dl1;
            out_bin   <= dv1 ? merged : '0;
        end
    end

endmodule

// File: rtl/mh_accum_chk.sv
module mh_accum_chk (
    input logic clk,
    input logic rst_n,
    input logic clear_req,
    input logic done_req,
    input logic busy,
    input logic acc_fire,
    input logic out_valid,
    input logic out_last
);
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R6
    AST_STREAM_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid); // R6
    AST_DUMP_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && done_req && !clear_req) |=> busy); // R6
    AST_NO_TAKE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !acc_fire); // R5
    AST_NO_TAKE_WITH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |-> !acc_fire); // R5
    AST_CLEAR_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && clear_req) |=> busy); // R8
endmodule

bind mh_accum mh_accum_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_req(clear_req),
    .done_req (done_req),
    .busy     (busy),
    .acc_fire (acc_fire),
    .out_valid(out_valid),
    .out_last (out_last)
);

// File: tb/mh_accum_tb_top.sv
`timescale 1ns/1ps
module mh_accum_tb_top;
    localparam int INT_W  = 8;
    localparam int FRAC_W = 8;
    localparam int BIN_W  = 4;
    localparam int N_NB   = 8;
    localparam int WORD_W = INT_W + FRAC_W;
    localparam int NBINS  = 1 << (2*BIN_W);
    localparam int SUM_W  = WORD_W + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_req = 1'b0;
    logic done_req = 1'b0;
    logic vox_valid = 1'b0;
    logic [INT_W-1:0] ref_pix = '0;
    logic [N_NB*INT_W-1:0] flt_pix = '0;
    logic [N_NB*WORD_W-1:0] wgt = '0;
    logic busy, out_valid, out_last;
    logic [SUM_W-1:0] out_bin;

    always #2 clk = ~clk;

    mh_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W), .BIN_W(BIN_W), .N_NB(N_NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear_req(clear_req), .done_req(done_req),
        .vox_valid(vox_valid), .ref_pix(ref_pix), .flt_pix(flt_pix), .wgt(wgt),
        .busy(busy), .out_valid(out_valid), .out_bin(out_bin), .out_last(out_last)
    );

    int checks = 0;
    int errors = 0;
    int unsigned model [NBINS];
    logic [SUM_W-1:0] got [NBINS];
    logic [7:0]  fv [N_NB];
    logic [15:0] wv [N_NB];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int bin_of(input logic [7:0] r, input logic [7:0] f);
        return int'(r >> (8-BIN_W)) * (1 << BIN_W) + int'(f >> (8-BIN_W));
    endfunction

    task automatic model_zero();
        for (int i = 0; i < NBINS; i++) model[i] = 0;
    endtask

    task automatic fill_rand(input bit narrow);
        for (int k = 0; k < N_NB; k++) begin
            fv[k] = narrow ? 8'(8'h40 + $urandom_range(0, 31)) : 8'($urandom_range(0, 255));
            wv[k] = 16'($urandom_range(1, 255));
        end
    endtask

    // drive one voxel for one cycle; count it in the model when it should be accepted
    task automatic drive_vox(input logic [7:0] r, input bit count);
        ref_pix = r;
        for (int k = 0; k < N_NB; k++) begin
            flt_pix[k*INT_W +: INT_W] = fv[k];
            wgt[k*WORD_W +: WORD_W]   = wv[k];
        end
        vox_valid = 1'b1;
        if (count) begin
            for (int k = 0; k < N_NB; k++) model[bin_of(r, fv[k])] += wv[k];
        end
        @(negedge clk);
    endtask

    task automatic do_clear(input bit vox_with_req, input bit junk, input string req);
        int n;
        if (vox_with_req) begin
            for (int k = 0; k < N_NB; k++) begin fv[k] = 8'h00; wv[k] = 16'h0077; end
            clear_req = 1'b1;
            drive_vox(8'h00, 1'b0);
        end else begin
            clear_req = 1'b1;
            vox_valid = 1'b0;
            @(negedge clk);
        end
        clear_req = 1'b0;
        vox_valid = 1'b0;
        n = 1;
        while (busy && n < 4*NBINS) begin
            if (junk) begin
                fill_rand(1'b0);
                drive_vox(8'($urandom_range(0, 255)), 1'b0);
            end else begin
                @(negedge clk);
            end
            n++;
        end
        vox_valid = 1'b0;
        chk(n == NBINS + 1, req, "cycles from clear request to idle", n, NBINS + 1);
        model_zero();
    endtask

    task automatic run_dump(input bit issue, input bit junk, input string req);
        int got_n, gaps, last_pos, last_cnt, mism, first_bad;
        bit started;
        if (issue) begin
            chk(busy == 1'b0, req, "busy before dump request", busy, 0);
            done_req = 1'b1;
            @(negedge clk);
            done_req = 1'b0;
            chk(busy == 1'b1, "R6", "busy one cycle after done_req", busy, 1);
        end
        got_n = 0; gaps = 0; last_pos = -1; last_cnt = 0; started = 1'b0;
        fork
            begin
                repeat (NBINS + 12) begin
                    @(negedge clk);
                    if (out_valid) begin
                        if (got_n < NBINS) got[got_n] = out_bin;
                        if (out_last) begin last_cnt++; last_pos = got_n; end
                        got_n++;
                        started = 1'b1;
                    end else if (started && got_n < NBINS) begin
                        gaps++;
                    end
                end
            end
            begin
                if (junk) begin
                    repeat (40) begin
                        fill_rand(1'b1);
                        drive_vox(8'($urandom_range(0, 255)), 1'b0);
                    end
                    vox_valid = 1'b0;
                end
            end
        join
        chk(got_n == NBINS, "R6", "words in dump", got_n, NBINS);
        chk(gaps == 0, "R6", "idle cycles inside dump stream", gaps, 0);
        chk(last_cnt == 1 && last_pos == NBINS - 1, "R6", "position of last flag", last_pos, NBINS - 1);
        mism = 0; first_bad = 0;
        for (int i = 0; i < NBINS; i++) begin
            if (got[i] !== SUM_W'(model[i])) begin
                if (mism == 0) first_bad = i;
                mism++;
            end
        end
        chk(mism == 0, req, $sformatf("bin values, first bad bin %0d", first_bad),
            longint'(got[first_bad]), longint'(model[first_bad]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL all watchdog expired actual=150000 expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4711));
        model_zero();
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R1", "busy during reset", busy, 1);
        chk(out_valid == 1'b0, "R1", "out_valid during reset", out_valid, 0);
        rst_n = 1'b1;
        n = 0;
        while (busy && n < 4*NBINS) begin @(negedge clk); n++; end
        chk(n == NBINS, "R1", "clear cycles after reset", n, NBINS);
        run_dump(1'b1, 1'b0, "R1");

        // R2: distinct neighbours, one voxel each
        fv = '{8'h00, 8'h1F, 8'h20, 8'h47, 8'h88, 8'hA0, 8'hC3, 8'hFF};
        for (int k = 0; k < N_NB; k++) wv[k] = 16'(11 * (k + 1));
        drive_vox(8'h35, 1'b1);
        vox_valid = 1'b0;
        @(negedge clk);
        fv = '{8'hF0, 8'h0E, 8'h77, 8'h78, 8'h5A, 8'h3C, 8'hB1, 8'hD2};
        for (int k = 0; k < N_NB; k++) wv[k] = 16'(200 - 7*k);
        drive_vox(8'hF0, 1'b1);
        vox_valid = 1'b0;
        run_dump(1'b1, 1'b0, "R2");

        // R3: all neighbours into one bin
        do_clear(1'b0, 1'b0, "R8");
        for (int k = 0; k < N_NB; k++) begin fv[k] = 8'(8'h90 + k); wv[k] = 16'(30 + k); end
        drive_vox(8'h7A, 1'b1);
        vox_valid = 1'b0;
        run_dump(1'b1, 1'b0, "R3");

        // R4: back-to-back hits on the same bins
        do_clear(1'b0, 1'b0, "R8");
        for (int k = 0; k < N_NB; k++) begin fv[k] = 8'(8'h20 + 16*k); wv[k] = 16'(17 + k); end
        repeat (6) drive_vox(8'h51, 1'b1);
        for (int j = 0; j < 6; j++) drive_vox((j % 2) ? 8'h51 : 8'hC4, 1'b1);
        vox_valid = 1'b0;
        run_dump(1'b1, 1'b0, "R4");

        // R5: voxel with clear_req and voxels during clear are refused
        do_clear(1'b1, 1'b1, "R8");
        run_dump(1'b1, 1'b0, "R5");

        // random stream with collisions, then R7 voxel together with done_req
        for (int v = 0; v < 300; v++) begin
            bit narrow;
            narrow = ($urandom_range(0, 1) == 1);
            fill_rand(narrow);
            drive_vox(narrow ? 8'(8'h60 + $urandom_range(0, 31)) : 8'($urandom_range(0, 255)), 1'b1);
            if ($urandom_range(0, 3) == 0) begin
                vox_valid = 1'b0;
                @(negedge clk);
            end
        end
        for (int k = 0; k < N_NB; k++) begin fv[k] = 8'hE9; wv[k] = 16'(3 + k); end
        done_req = 1'b1;
        drive_vox(8'h0B, 1'b1);
        done_req = 1'b0;
        vox_valid = 1'b0;
        chk(busy == 1'b1, "R7", "busy after done_req with voxel", busy, 1);
        run_dump(1'b0, 1'b1, "R7");
        run_dump(1'b1, 1'b0, "R9");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule